// File: doc/BRIEF.md
# Permission-Split Direct-Mapped Translation Buffer

This block caches virtual-to-physical page translations in a direct-mapped table. Loads, stores and instruction fetches each have their own tag array, and all three share one array of physical page numbers. A lookup presents a virtual address and an access class. On a hit, the block returns the physical address in the same cycle. On a miss, it raises a refill request.

The page-table walker answers a refill request through the refill port. It supplies the virtual address, the physical page number and three permission bits: read, write and execute. The block writes the page number and writes each class tag only when that class is permitted. Every class without permission is marked invalid. A refill flagged as no-install still returns its translated address but leaves the table untouched, so later accesses to that page keep missing. A flush input invalidates all three tag arrays.

The page size defaults to 4 KiB and the table defaults to 256 entries. The address widths, page shift and entry count are all parameters.

Top module: `tlb_perm_split`

## Requirements
- R1: After reset no lookup hits. While lkValid is high, exactly one of lkHit and lkMiss is high. While lkValid is low, both are low.
- R2: The entry index is the low log2(ENTRIES) bits of the virtual page number (address bits above PAGE_SHIFT). A refill to a page replaces whatever page held the same index.
- R3: A hit needs the stored tag to equal the whole virtual page number. A different page that shares the index misses.
- R4: The tag array checked is picked by access class. lkFetch=1 selects the fetch array whatever lkStore is. Otherwise lkStore=1 selects the store array, and otherwise the load array is used.
- R5: An installing refill writes the load tag if rfRead=1, the store tag if rfWrite=1 and the fetch tag if rfExec=1. At that index, every class whose bit is 0 becomes invalid, even if it was valid before.
- R6: In the same cycle as a lookup hit, lkPaddr equals the stored page number followed by the PAGE_SHIFT offset bits of lkVaddr. On a miss lkPaddr is 0.
- R7: rfPaddr always equals rfPpn followed by the offset bits of rfVaddr, with or without rfNoInstall.
- R8: A refill with rfNoInstall=1 changes no tag and no page entry. A previously installed page at that index still hits, and the refilled page still misses.
- R9: flush invalidates every tag of all three classes from the next cycle on. A refill in the same cycle as a flush is dropped.
- R10: The invalid tag value is all ones, so a page whose number is all ones never hits, even after a refill.
- R11: A refill takes effect at the clock edge that ends its cycle. A lookup in that same cycle sees the old contents, and a lookup in the next cycle sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, invalidates all tags |
| flush | input | 1 | Invalidate every entry |
| lkValid | input | 1 | Lookup present |
| lkVaddr | input | VA_W | Lookup virtual address |
| lkStore | input | 1 | Lookup is a store |
| lkFetch | input | 1 | Lookup is an instruction fetch |
| lkHit | output | 1 | Translation found |
| lkMiss | output | 1 | Refill request |
| lkPaddr | output | PA_W | Translated address on hit, 0 otherwise |
| rfValid | input | 1 | Refill present |
| rfVaddr | input | VA_W | Virtual address being refilled |
| rfPpn | input | PA_W-PAGE_SHIFT | Physical page number |
| rfRead | input | 1 | Read permission |
| rfWrite | input | 1 | Write permission |
| rfExec | input | 1 | Execute permission |
| rfNoInstall | input | 1 | Return the translation without updating the table |
| rfPaddr | output | PA_W | Translated refill address |

## Verification
The bench builds the block with 16 entries, a 20-bit virtual address and a 24-bit physical address, keeping the 4 KiB page. The virtual page number is then 8 bits wide: 4 index bits and 4 tag bits. This makes index aliasing, a sweep over every entry and the all-ones page number easy to reach with short address values. A scoreboard model of the three tag arrays predicts every lookup. The bench covers permission subsets, class priority, no-install refills, a flush that coincides with a refill, and a lookup in the same cycle as a refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    CLS_LOAD  = 2'd0,
    CLS_STORE = 2'd1,
    CLS_FETCH = 2'd2
  } accCls_e;

  localparam int NUM_CLS = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic             clearAll;   // invalidate every tag
    logic             install;    // write refill into the table
    logic [NUM_CLS-1:0] grant;    // per-class permission, indexed by accCls_e
    accCls_e          sel;        // class used for the lookup compare
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_entry_ram.sv
module tlb_entry_ram #(
  parameter int ENTRIES  = 256,
  parameter int WIDTH    = 20,
  parameter bit FILL_ONE = 1'b1,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [WIDTH-1:0] wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [WIDTH-1:0] rdData
);

  localparam logic [WIDTH-1:0] FILL = FILL_ONE ? '1 : '0;

  logic [WIDTH-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= FILL;
    end else if (wrEn) begin
      mem[wrIdx] <= wrData;
    end
  end

  assign rdData = mem[rdIdx];

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic       flush,
  input  logic       lkStore,
  input  logic       lkFetch,
  input  logic       rfValid,
  input  logic       rfRead,
  input  logic       rfWrite,
  input  logic       rfExec,
  input  logic       rfNoInstall,
  output tlbStrobe_t strobe
);

  accCls_e selCls;

  // fetch outranks store, store outranks load
  always_comb begin
    if (lkFetch)      selCls = CLS_FETCH;
    else if (lkStore) selCls = CLS_STORE;
    else              selCls = CLS_LOAD;
  end

  always_comb begin
    strobe = '0;
    strobe.clearAll = flush;
    // a flush drops any refill arriving in the same cycle
    strobe.install  = rfValid && !rfNoInstall && !flush;
    strobe.grant[CLS_LOAD]  = rfRead;
    strobe.grant[CLS_STORE] = rfWrite;
    strobe.grant[CLS_FETCH] = rfExec;
    strobe.sel = selCls;
  end

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 34,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 256,
  localparam int VPN_W     = VA_W - PAGE_SHIFT,
  localparam int PPN_W     = PA_W - PAGE_SHIFT,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic             lkValid,
  input  logic [VA_W-1:0]  lkVaddr,
  input  logic [VA_W-1:0]  rfVaddr,
  input  logic [PPN_W-1:0] rfPpn,
  output logic             lkHit,
  output logic             lkMiss,
  output logic [PA_W-1:0]  lkPaddr,
  output logic [PA_W-1:0]  rfPaddr
);

  logic [VPN_W-1:0] lkVpn, rfVpn;
  logic [IDX_W-1:0] lkIdx, rfIdx;
  logic [VPN_W-1:0] clsTag [NUM_CLS];
  logic [VPN_W-1:0] selTag;
  logic [PPN_W-1:0] pageRd;
  logic             tagMatch;

  assign lkVpn = lkVaddr[VA_W-1:PAGE_SHIFT];
  assign rfVpn = rfVaddr[VA_W-1:PAGE_SHIFT];
  assign lkIdx = lkVpn[IDX_W-1:0];
  assign rfIdx = rfVpn[IDX_W-1:0];

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic [VPN_W-1:0] wrTag;
    assign wrTag = strobe.grant[c] ? rfVpn : '1;
    tlb_entry_ram #(
      .ENTRIES (ENTRIES),
      .WIDTH   (VPN_W),
      .FILL_ONE(1'b1)
    ) u_tags (
      .clk   (clk),
      .rstN  (rstN),
      .clear (strobe.clearAll),
      .wrEn  (strobe.install),
      .wrIdx (rfIdx),
      .wrData(wrTag),
      .rdIdx (lkIdx),
      .rdData(clsTag[c])
    );
  end

  tlb_entry_ram #(
    .ENTRIES (ENTRIES),
    .WIDTH   (PPN_W),
    .FILL_ONE(1'b0)
  ) u_pages (
    .clk   (clk),
    .rstN  (rstN),
    .clear (1'b0),
    .wrEn  (strobe.install),
    .wrIdx (rfIdx),
    .wrData(rfPpn),
    .rdIdx (lkIdx),
    .rdData(pageRd)
  );

  always_comb begin
    unique case (strobe.sel)
      CLS_FETCH: selTag = clsTag[CLS_FETCH];
      CLS_STORE: selTag = clsTag[CLS_STORE];
      default:   selTag = clsTag[CLS_LOAD];
    endcase
  end

  // all-ones marks an invalid tag, so it can never count as a match
  assign tagMatch = (selTag == lkVpn) && (selTag != '1);

  assign lkHit   = lkValid && tagMatch;
  assign lkMiss  = lkValid && !tagMatch;
  assign lkPaddr = lkHit ? {pageRd, lkVaddr[PAGE_SHIFT-1:0]} : '0;
  assign rfPaddr = {rfPpn, rfVaddr[PAGE_SHIFT-1:0]};

endmodule

// File: rtl/tlb_perm_split.sv
module tlb_perm_split
  import tlb_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 34,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 256,
  localparam int PPN_W     = PA_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             lkValid,
  input  logic [VA_W-1:0]  lkVaddr,
  input  logic             lkStore,
  input  logic             lkFetch,
  output logic             lkHit,
  output logic             lkMiss,
  output logic [PA_W-1:0]  lkPaddr,
  input  logic             rfValid,
  input  logic [VA_W-1:0]  rfVaddr,
  input  logic [PPN_W-1:0] rfPpn,
  input  logic             rfRead,
  input  logic             rfWrite,
  input  logic             rfExec,
  input  logic             rfNoInstall,
  output logic [PA_W-1:0]  rfPaddr
);

  tlbStrobe_t strobe;

  tlb_ctrl u_ctrl (
    .flush      (flush),
    .lkStore    (lkStore),
    .lkFetch    (lkFetch),
    .rfValid    (rfValid),
    .rfRead     (rfRead),
    .rfWrite    (rfWrite),
    .rfExec     (rfExec),
    .rfNoInstall(rfNoInstall),
    .strobe     (strobe)
  );

  tlb_datapath #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .ENTRIES   (ENTRIES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .lkValid(lkValid),
    .lkVaddr(lkVaddr),
    .rfVaddr(rfVaddr),
    .rfPpn  (rfPpn),
    .lkHit  (lkHit),
    .lkMiss (lkMiss),
    .lkPaddr(lkPaddr),
    .rfPaddr(rfPaddr)
  );

endmodule

// File: rtl/tlb_perm_split_chk.sv
module tlb_perm_split_chk #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 34,
  parameter int PAGE_SHIFT = 12,
  localparam int PPN_W     = PA_W - PAGE_SHIFT,
  localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
  input logic             clk,
  input logic             rstN,
  input logic             flush,
  input logic             lkValid,
  input logic [VA_W-1:0]  lkVaddr,
  input logic             lkStore,
  input logic             lkFetch,
  input logic             lkHit,
  input logic             lkMiss,
  input logic [PA_W-1:0]  lkPaddr,
  input logic             rfValid,
  input logic [VA_W-1:0]  rfVaddr,
  input logic [PPN_W-1:0] rfPpn,
  input logic             rfRead,
  input logic             rfWrite,
  input logic             rfExec,
  input logic             rfNoInstall
);

  logic [VPN_W-1:0] lkVpn, rfVpn;
  assign lkVpn = lkVaddr[VA_W-1:PAGE_SHIFT];
  assign rfVpn = rfVaddr[VA_W-1:PAGE_SHIFT];

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lkHit, lkMiss}) && ((lkHit || lkMiss) == lkValid)); // R1

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !lkHit); // R9

  AST_ONES_NEVER_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && (lkVpn == '1)) |-> !lkHit); // R10

  AST_INSTALL_HITS: assert property (@(posedge clk) disable iff (!rstN)
    (rfValid && !rfNoInstall && !flush && rfRead && rfWrite && rfExec && (rfVpn != '1))
    |=> (!(lkValid && (lkVpn == $past(rfVpn))) ||
         (lkHit && (lkPaddr[PA_W-1:PAGE_SHIFT] == $past(rfPpn))))); // R11

  AST_NOINSTALL_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (lkMiss && rfValid && rfNoInstall && (lkVpn == rfVpn))
    |=> (!(lkValid && $stable(lkVaddr) && $stable(lkStore) && $stable(lkFetch)) || lkMiss)); // R8

endmodule

bind tlb_perm_split tlb_perm_split_chk #(
  .VA_W      (VA_W),
  .PA_W      (PA_W),
  .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .flush      (flush),
  .lkValid    (lkValid),
  .lkVaddr    (lkVaddr),
  .lkStore    (lkStore),
  .lkFetch    (lkFetch),
  .lkHit      (lkHit),
  .lkMiss     (lkMiss),
  .lkPaddr    (lkPaddr),
  .rfValid    (rfValid),
  .rfVaddr    (rfVaddr),
  .rfPpn      (rfPpn),
  .rfRead     (rfRead),
  .rfWrite    (rfWrite),
  .rfExec     (rfExec),
  .rfNoInstall(rfNoInstall)
);

// File: tb/tlb_perm_split_tb.sv
module tlb_perm_split_tb;

  localparam int VA_W = 20;
  localparam int PA_W = 24;
  localparam int PS   = 12;
  localparam int ENT  = 16;
  localparam int VPNW = VA_W - PS;
  localparam int PPNW = PA_W - PS;
  localparam int IW   = $clog2(ENT);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic lkValid = 1'b0, lkStore = 1'b0, lkFetch = 1'b0;
  logic [VA_W-1:0] lkVaddr = '0;
  logic lkHit, lkMiss;
  logic [PA_W-1:0] lkPaddr, rfPaddr;
  logic rfValid = 1'b0, rfRead = 1'b0, rfWrite = 1'b0, rfExec = 1'b0, rfNoInstall = 1'b0;
  logic [VA_W-1:0] rfVaddr = '0;
  logic [PPNW-1:0] rfPpn = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tlb_perm_split #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PS), .ENTRIES(ENT)) u_dut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .lkValid(lkValid), .lkVaddr(lkVaddr), .lkStore(lkStore), .lkFetch(lkFetch),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkPaddr(lkPaddr),
    .rfValid(rfValid), .rfVaddr(rfVaddr), .rfPpn(rfPpn),
    .rfRead(rfRead), .rfWrite(rfWrite), .rfExec(rfExec),
    .rfNoInstall(rfNoInstall), .rfPaddr(rfPaddr)
  );

  // reference model: index 0 load, 1 store, 2 fetch
  logic [VPNW-1:0] mTag [3][ENT];
  logic [PPNW-1:0] mPage [ENT];

  typedef struct {
    logic            hit;
    logic [PA_W-1:0] pa;
    string           req;
  } expItem_t;
  expItem_t expQ[$];

  // monitor: compare every lookup result against the scoreboard
  always @(negedge clk) begin
    if (rstN && lkValid) begin
      expItem_t e;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected lookup result hit=%0b", "R1", lkHit);
      end else begin
        e = expQ.pop_front();
        if (lkHit !== e.hit || lkMiss !== !e.hit || lkPaddr !== e.pa) begin
          errors++;
          $display("FAIL %s: hit=%0b miss=%0b pa=%h expected hit=%0b pa=%h",
                   e.req, lkHit, lkMiss, lkPaddr, e.hit, e.pa);
        end
      end
    end
  end

  task automatic step(input logic doLk, input logic [VA_W-1:0] va, input logic st,
                      input logic fe, input logic doRf, input logic [VA_W-1:0] rva,
                      input logic [PPNW-1:0] ppn, input logic r, input logic w,
                      input logic x, input logic ni, input logic doFl, input string req);
    expItem_t e;
    logic [VPNW-1:0] vpn, rvpn;
    logic [IW-1:0] idx, ridx;
    int cls;
    @(posedge clk);
    #1;
    lkValid = doLk; lkVaddr = va; lkStore = st; lkFetch = fe;
    rfValid = doRf; rfVaddr = rva; rfPpn = ppn; rfRead = r; rfWrite = w; rfExec = x;
    rfNoInstall = ni; flush = doFl;
    vpn = va[VA_W-1:PS]; idx = vpn[IW-1:0];
    rvpn = rva[VA_W-1:PS]; ridx = rvpn[IW-1:0];
    if (doLk) begin
      cls = fe ? 2 : (st ? 1 : 0);
      e.hit = (mTag[cls][idx] == vpn) && (vpn != '1);
      e.pa  = e.hit ? {mPage[idx], va[PS-1:0]} : '0;
      e.req = req;
      expQ.push_back(e);
    end
    @(negedge clk);
    if (!doLk) begin
      checks++;
      if (lkHit !== 1'b0 || lkMiss !== 1'b0) begin
        errors++;
        $display("FAIL R1: idle hit=%0b miss=%0b expected 0 0", lkHit, lkMiss);
      end
    end
    if (doRf) begin
      checks++;
      if (rfPaddr !== {ppn, rva[PS-1:0]}) begin
        errors++;
        $display("FAIL R7: rfPaddr=%h expected %h", rfPaddr, {ppn, rva[PS-1:0]});
      end
    end
    // model update at the coming edge
    if (doFl) begin
      for (int c = 0; c < 3; c++) for (int i = 0; i < ENT; i++) mTag[c][i] = '1;
    end else if (doRf && !ni) begin
      mTag[0][ridx] = r ? rvpn : '1;
      mTag[1][ridx] = w ? rvpn : '1;
      mTag[2][ridx] = x ? rvpn : '1;
      mPage[ridx] = ppn;
    end
  endtask

  task automatic lk(input logic [VA_W-1:0] va, input logic st, input logic fe, input string req);
    step(1'b1, va, st, fe, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic rf(input logic [VA_W-1:0] va, input logic [PPNW-1:0] ppn,
                    input logic r, input logic w, input logic x, input logic ni);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, va, ppn, r, w, x, ni, 1'b0, "R7");
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++) for (int i = 0; i < ENT; i++) mTag[c][i] = '1;
    for (int i = 0; i < ENT; i++) mPage[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: empty after reset
    idle();
    lk(20'h01234, 1'b0, 1'b0, "R1");
    lk(20'h01234, 1'b0, 1'b1, "R1");

    // R5 R6: read-only page
    rf(20'h01234, 12'h0AB, 1'b1, 1'b0, 1'b0, 1'b0);
    lk(20'h01FFF, 1'b0, 1'b0, "R6");
    lk(20'h01000, 1'b1, 1'b0, "R5");
    lk(20'h01000, 1'b0, 1'b1, "R5");

    // R5: regrant write+exec only, load becomes invalid
    rf(20'h01010, 12'h0CD, 1'b0, 1'b1, 1'b1, 1'b0);
    lk(20'h01010, 1'b0, 1'b0, "R5");
    lk(20'h01ABC, 1'b1, 1'b0, "R6");
    lk(20'h01ABC, 1'b1, 1'b1, "R4");

    // R4: exec-only page, fetch wins over store
    rf(20'h05000, 12'h777, 1'b0, 1'b0, 1'b1, 1'b0);
    lk(20'h05123, 1'b1, 1'b1, "R4");
    lk(20'h05123, 1'b1, 1'b0, "R4");

    // R3 R2: alias at index 1
    lk(20'h11000, 1'b1, 1'b0, "R3");
    rf(20'h11000, 12'h222, 1'b1, 1'b0, 1'b0, 1'b0);
    lk(20'h01000, 1'b1, 1'b0, "R2");
    lk(20'h11456, 1'b0, 1'b0, "R2");

    // R8: no-install leaves index 1 alone
    rf(20'h21000, 12'h999, 1'b1, 1'b1, 1'b1, 1'b1);
    lk(20'h11456, 1'b0, 1'b0, "R8");
    lk(20'h21456, 1'b0, 1'b0, "R8");

    // R11: lookup concurrent with its refill sees old state
    step(1'b1, 20'h31008, 1'b0, 1'b0, 1'b1, 20'h31000, 12'h333,
         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
    lk(20'h31008, 1'b0, 1'b0, "R11");

    // R10: all-ones page never hits
    rf(20'hFF000, 12'h444, 1'b1, 1'b1, 1'b1, 1'b0);
    lk(20'hFF010, 1'b0, 1'b0, "R10");
    lk(20'hFF010, 1'b0, 1'b1, "R10");

    // R9: flush with a concurrent refill that must be dropped
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, 20'h42000, 12'h555,
         1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
    lk(20'h42000, 1'b0, 1'b0, "R9");
    lk(20'h31008, 1'b0, 1'b0, "R9");
    lk(20'h05123, 1'b0, 1'b1, "R9");

    // R2: sweep every index
    for (int i = 0; i < ENT; i++)
      rf({4'h6, 4'(i), 12'h0}, 12'h100 + 12'(i), 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < ENT; i++)
      lk({4'h6, 4'(i), 12'h0F0}, 1'b0, 1'b0, "R2");
    lk(20'h76000, 1'b0, 1'b0, "R3");

    idle();
    @(posedge clk);
    #1;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d lookups without result, expected 0", expQ.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule